// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a serial-input DAC. A data word goes in one bit at a time, most significant bit first, into a shift register. The shift clock is built from four strobe inputs. Three of them act on a rising transition and one acts on a falling transition. A bit is taken only when the strobe that moves reaches its active level while the other three already sit at theirs. The bit that leaves the top of the shift register is presented on a serial output, so several devices can be chained with a delay of one word each.

Two active-low load inputs copy the shift register into the DAC holding register. The copy happens once, on the first system clock where both are seen low. An active-low clear overrides the load and forces the holding register to zero scale or, by a build-time parameter, to midscale. The clear leaves the shift register untouched. Every pin is sampled in the system clock domain through two-flop synchronizers. The parallel DAC code is the block's output.

Top module: `dac_serial_front`

## Requirements
- R1: After reset, `dac_code` equals the clear target (0 for `CLEAR_MODE` = zero scale, 0x800 for midscale) and `sdata_o` is 0.
- R2: Twelve accepted shifts followed by a load make `dac_code` equal the word presented MSB first on `sdata_i`.
- R3: No bit is accepted when a strobe reaches its active level while any other strobe is away from its enabling level.
- R4: Strobes at indices 0, 1 and 3 act on a rising transition and enable when high. Strobe index 2 acts on a falling transition and enables when low. Any one of the four may deliver the shift.
- R5: Each accepted shift moves the former MSB of the shift register onto `sdata_o`. As a result, a word appears on `sdata_o` MSB first while the next word is shifted in.
- R6: `dac_code` is loaded only when both `load_a_n` and `load_b_n` are low. Either one alone has no effect.
- R7: The load happens once per interval in which both load inputs are low. Shifts made while both stay low do not reach `dac_code`.
- R8: While `clear_n` is low, `dac_code` holds the clear target: 0x000 for zero scale, 0x800 for midscale.
- R9: Clear takes priority over load, and clear does not alter the shift register. A later load delivers the word shifted in before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 4 | Shift strobes; index 2 falling-active, others rising-active |
| load_a_n | input | 1 | Load control A, active low |
| load_b_n | input | 1 | Load control B, active low |
| clear_n | input | 1 | Clear, active low |
| sdata_i | input | 1 | Serial data in, MSB first |
| sdata_o | output | 1 | Bit shifted out of the MSB, for chaining |
| dac_code | output | 12 | DAC holding register contents |

## Verification
The assertions assume that every pin is quasi-static relative to the system clock. They also assume that `sdata_i` is settled before the strobe that captures it and stays stable until that strobe has passed the synchronizers. The stimulus changes one group of inputs at a time on the falling clock edge and waits four clocks after each change. Each strobe therefore reaches its enabling level a full synchronizer delay before the active transition, and the data line never moves within that window.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic {
        CLR_ZERO = 1'b0,
        CLR_MID  = 1'b1
    } clr_target_e;

    // Synchronized control pins travel together as one word.
    typedef struct packed {
        logic load_a_n;
        logic load_b_n;
        logic clear_n;
        logic sdata;
    } ctrl_s;

    localparam ctrl_s CTRL_IDLE = '{load_a_n: 1'b1, load_b_n: 1'b1,
                                    clear_n: 1'b1, sdata: 1'b0};

    function automatic logic [31:0] clear_code(input clr_target_e mode,
                                               input int unsigned width);
        logic [31:0] v;
        v = '0;
        if (mode == CLR_MID) v[width-1] = 1'b1;
        return v;
    endfunction

    // Inactive level of each strobe: the level left behind by its idle state.
    function automatic logic [3:0] idle_levels(input logic [3:0] active_low_mask);
        return active_low_mask;
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RESET_VAL;
            stage2 <= RESET_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/dacfe_strobe_gate.sv
module dacfe_strobe_gate #(
    parameter int unsigned NSTROBE = 4,
    parameter logic [NSTROBE-1:0] ACTIVE_LOW_MASK = 4'b0100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTROBE-1:0] strobe_s,
    output logic               shift_pulse
);
    logic [NSTROBE-1:0] en_now;
    logic [NSTROBE-1:0] en_prev;
    logic [NSTROBE-1:0] fired;

    for (genvar i = 0; i < NSTROBE; i++) begin : g_lane
        // Enabling level equals the level reached by the active transition.
        assign en_now[i] = ACTIVE_LOW_MASK[i] ? ~strobe_s[i] : strobe_s[i];
        assign fired[i]  = en_now[i] & ~en_prev[i];
    end

    always_ff @(posedge clk) begin
        if (rst) en_prev <= '0;
        else     en_prev <= en_now;
    end

    assign shift_pulse = (&en_now) & (|fired);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse); // R3

    AST_PULSE_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |-> (strobe_s == ~ACTIVE_LOW_MASK)); // R4

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_pulse,
    input  logic             sdata,
    output logic [WIDTH-1:0] shreg,
    output logic             sout
);
    localparam int unsigned MSB = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sout  <= 1'b0;
        end else if (shift_pulse) begin
            shreg <= {shreg[MSB-1:0], sdata};
            sout  <= shreg[MSB];
        end
    end

    AST_SOUT_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> sout == $past(shreg[MSB])); // R5

    AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> $stable(shreg) && $stable(sout)); // R3

    AST_LSB_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> shreg[0] == $past(sdata)); // R2

endmodule

// File: rtl/dacfe_holder.sv
module dacfe_holder #(
    parameter int unsigned WIDTH = 12,
    parameter logic [WIDTH-1:0] CLEAR_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  dacfe_pkg::ctrl_s ctrl,
    input  logic [WIDTH-1:0] shreg,
    output logic [WIDTH-1:0] code
);
    logic both_low;
    logic both_low_prev;
    logic load_evt;
    logic clr_act;

    assign both_low = ~ctrl.load_a_n & ~ctrl.load_b_n;
    assign load_evt = both_low & ~both_low_prev;
    assign clr_act  = ~ctrl.clear_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            both_low_prev <= 1'b0;
            code          <= CLEAR_VAL;
        end else begin
            both_low_prev <= both_low;
            if (clr_act)       code <= CLEAR_VAL;
            else if (load_evt) code <= shreg;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> code == CLEAR_VAL); // R8

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        (load_evt && !clr_act) |=> code == $past(shreg)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!load_evt && !clr_act) |=> $stable(code)); // R7

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
    parameter int unsigned WIDTH = 12,
    parameter dacfe_pkg::clr_target_e CLEAR_MODE = dacfe_pkg::CLR_ZERO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       strobe,
    input  logic             load_a_n,
    input  logic             load_b_n,
    input  logic             clear_n,
    input  logic             sdata_i,
    output logic             sdata_o,
    output logic [WIDTH-1:0] dac_code
);
    import dacfe_pkg::*;

    localparam int unsigned NSTROBE = 4;
    localparam logic [NSTROBE-1:0] ACTIVE_LOW_MASK = 4'b0100;
    localparam logic [31:0] CLEAR_WIDE = clear_code(CLEAR_MODE, WIDTH);
    localparam logic [WIDTH-1:0] CLEAR_VAL = CLEAR_WIDE[WIDTH-1:0];
    localparam logic [NSTROBE-1:0] STROBE_IDLE = idle_levels(ACTIVE_LOW_MASK);

    logic [NSTROBE-1:0] strobe_s;
    ctrl_s              ctrl_raw;
    ctrl_s              ctrl_s_q;
    logic               shift_pulse;
    logic [WIDTH-1:0]   shreg;

    assign ctrl_raw = '{load_a_n: load_a_n, load_b_n: load_b_n,
                        clear_n: clear_n, sdata: sdata_i};

    dacfe_sync #(.WIDTH(NSTROBE), .RESET_VAL(STROBE_IDLE)) u_sync_strobe (
        .clk (clk), .rst (rst), .d (strobe), .q (strobe_s)
    );

    dacfe_sync #(.WIDTH($bits(ctrl_s)), .RESET_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk (clk), .rst (rst), .d (ctrl_raw), .q (ctrl_s_q)
    );

    dacfe_strobe_gate #(.NSTROBE(NSTROBE), .ACTIVE_LOW_MASK(ACTIVE_LOW_MASK)) u_gate (
        .clk (clk), .rst (rst), .strobe_s (strobe_s), .shift_pulse (shift_pulse)
    );

    dacfe_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk (clk), .rst (rst), .shift_pulse (shift_pulse),
        .sdata (ctrl_s_q.sdata), .shreg (shreg), .sout (sdata_o)
    );

    dacfe_holder #(.WIDTH(WIDTH), .CLEAR_VAL(CLEAR_VAL)) u_hold (
        .clk (clk), .rst (rst), .ctrl (ctrl_s_q), .shreg (shreg), .code (dac_code)
    );

    AST_CLEAR_KEEPS_SHREG: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_s_q.clear_n && !shift_pulse) |=> $stable(shreg)); // R9

endmodule

// File: tb/dac_serial_front_bench.sv
module dac_serial_front_bench;
    localparam int W = 12;
    localparam logic [3:0] IDLE = 4'b0100;
    localparam logic [3:0] ENAB = 4'b1011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] strobe = IDLE;
    logic load_a_n = 1'b1, load_b_n = 1'b1, clear_n = 1'b1, sdata_i = 1'b0;
    logic sdata_o, sdata_o_mid;
    logic [W-1:0] dac_code, dac_code_mid;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dac_serial_front u_dac_serial_front (
        .clk(clk), .rst(rst), .strobe(strobe), .load_a_n(load_a_n),
        .load_b_n(load_b_n), .clear_n(clear_n), .sdata_i(sdata_i),
        .sdata_o(sdata_o), .dac_code(dac_code)
    );

    dac_serial_front #(.CLEAR_MODE(dacfe_pkg::CLR_MID)) u_dac_serial_front_mid (
        .clk(clk), .rst(rst), .strobe(strobe), .load_a_n(load_a_n),
        .load_b_n(load_b_n), .clear_n(clear_n), .sdata_i(sdata_i),
        .sdata_o(sdata_o_mid), .dac_code(dac_code_mid)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Shift one bit using strobe index 'who'; when 'spoil' >= 0 that strobe
    // is left at its idle level, so no shift should be accepted.
    task automatic shift_bit(input logic b, input int who, input int spoil);
        logic [3:0] pre;
        @(negedge clk);
        sdata_i = b;
        pre = ENAB;
        pre[who] = IDLE[who];
        if (spoil >= 0) pre[spoil] = IDLE[spoil];
        strobe = pre;
        settle();
        strobe[who] = ENAB[who];
        settle();
        strobe = IDLE;
        settle();
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i], i % 4, -1);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        load_a_n = 1'b0; load_b_n = 1'b0;
        settle();
        load_a_n = 1'b1; load_b_n = 1'b1;
        settle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] a, b, w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 zero", dac_code, 12'h000);
        chk("R1 mid", dac_code_mid, 12'h800);
        chk("R1 sout", {11'b0, sdata_o}, 12'h000);

        // R2/R4 sweep of words, strobes rotated per bit
        for (int k = 0; k < 24; k++) begin
            w = W'((k * 12'h9E3) ^ (k << 5) ^ 12'h5A5);
            shift_word(w);
            load_pulse();
            chk("R2 word", dac_code, w);
            chk("R2 word mid", dac_code_mid, w);
        end

        // R4 each single strobe delivers all shifts
        for (int s = 0; s < 4; s++) begin
            w = W'(12'h3C1 + s * 12'h111);
            for (int i = W - 1; i >= 0; i--) shift_bit(w[i], s, -1);
            load_pulse();
            chk("R4 single strobe", dac_code, w);
        end

        // R5 serial out delay
        a = 12'hB37; b = 12'h4C9;
        shift_word(a);
        for (int i = W - 1; i >= 0; i--) begin
            shift_bit(b[i], i % 4, -1);
            chk("R5 sout", {11'b0, sdata_o}, {11'b0, a[i]});
        end

        // R3 spoiled shifts ignored
        w = 12'h6A2;
        shift_word(w);
        for (int s = 0; s < 4; s++) shift_bit(1'b1, s, (s + 1) % 4);
        load_pulse();
        chk("R3 spoiled ignored", dac_code, w);

        // R6 single load input alone
        shift_word(12'h1F0);
        @(negedge clk); load_a_n = 1'b0; settle();
        chk("R6 load_a only", dac_code, w);
        load_a_n = 1'b1; load_b_n = 1'b0; settle();
        chk("R6 load_b only", dac_code, w);
        load_b_n = 1'b1; settle();

        // R7 one load per low interval
        @(negedge clk); load_a_n = 1'b0; load_b_n = 1'b0; settle();
        chk("R7 first load", dac_code, 12'h1F0);
        shift_word(12'hE0D);
        chk("R7 no repeat", dac_code, 12'h1F0);
        load_a_n = 1'b1; load_b_n = 1'b1; settle();

        // R8 clear targets
        @(negedge clk); clear_n = 1'b0; settle();
        chk("R8 zero", dac_code, 12'h000);
        chk("R8 mid", dac_code_mid, 12'h800);

        // R9 clear beats load, shift register kept
        load_a_n = 1'b0; load_b_n = 1'b0; settle();
        chk("R9 clear wins", dac_code, 12'h000);
        chk("R9 clear wins mid", dac_code_mid, 12'h800);
        clear_n = 1'b1; settle();
        chk("R9 no late load", dac_code, 12'h000);
        load_a_n = 1'b1; load_b_n = 1'b1; settle();
        load_pulse();
        chk("R9 word kept", dac_code, 12'hE0D);
        chk("R9 word kept mid", dac_code_mid, 12'hE0D);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule